// File: doc/BRIEF.md
# Colour Lookup Table Write Port

This block holds a palette of colour entries and loads it through a narrow byte-wide host interface. The host first writes an entry number into a shared index register. It then writes the red, green and blue bytes of that entry, one after another, into the palette data port. The block gathers the three bytes and writes the assembled colour into the palette RAM only when the blue byte arrives. It then moves the index on to the next entry, so a run of consecutive entries can be loaded with a single index write.

The same index register also selects one of a few indexed 8-bit control registers. These are written through a separate control data port, using the same sequence: index first, then data. A display pipeline reads the palette on its own synchronous port. It presents a pixel index and gets the packed 24-bit colour one clock later.

Top module: `clut_port`

## Requirements
- R1: After reset the index register is 0, the channel sequencer expects red, and all four control registers read 0x00.
- R2: A host write with port select 0 (index port) loads the 8-bit data into the index register, so the next complete triplet lands at that entry.
- R3: Host writes with port select 1 (palette data port) supply red, then green, then blue. The committed entry reads back as {red[23:16], green[15:8], blue[7:0]}.
- R4: An entry changes in RAM only on the blue write. After only red and green writes, the entry still holds its previous colour.
- R5: After each blue write the index advances by one and the sequencer returns to red, so back-to-back triplets fill consecutive entries.
- R6: The index advance wraps from entry 255 to entry 0.
- R7: An index write discards any partly gathered triplet and restarts the sequence at red.
- R8: A host write with port select 2 (control data port) stores the 8-bit data in the control register whose index equals the index register, for indices 0x20, 0x21, 0x10 and 0x11. Each register reads back on ctlRdData when ctlRdAddr carries its index.
- R9: Control data writes to any other index change no control register. A control data write never moves the index register or the red/green/blue sequence. Port select 3 is ignored.
- R10: The palette read port is synchronous. pixRgb shows the entry addressed by pixIdx at the preceding rising clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| hostWe | input | 1 | Host write strobe, one write per cycle |
| hostSel | input | 2 | Port select: 0 index, 1 palette data, 2 control data, 3 unused |
| hostData | input | 8 | Host write byte |
| ctlRdAddr | input | 8 | Index of the control register to read back |
| ctlRdData | output | 8 | Control register contents, 0 for an unknown index |
| pixIdx | input | 8 | Pixel index for the palette read port |
| pixRgb | output | 24 | Packed colour, one cycle after pixIdx |

## Verification
The bench builds the block with its default parameters: 256 entries of three 8-bit channels, and four control registers. With these values the index register and the table index have the same width. The wrap from entry 255 to entry 0 can therefore be reached with one index write and two triplets. All four control indices and a non-matching index can be driven directly from the host port.

// File: rtl/clut_pkg.sv
package clut_pkg;

  localparam int CHAN_W  = 8;
  localparam int NUM_CTL = 4;

  typedef enum logic [1:0] {
    CH_RED = 2'd0,
    CH_GRN = 2'd1,
    CH_BLU = 2'd2
  } chanSel_t;

  typedef enum logic [1:0] {
    PORT_INDEX = 2'd0,
    PORT_LUT   = 2'd1,
    PORT_CTL   = 2'd2
  } hostPort_t;

  // strobes from the sequencer to the datapath
  typedef struct packed {
    logic ldRed;
    logic ldGrn;
    logic commit;
    logic ctlWr;
  } clutStrobe_t;

  // index register values that select each control register
  function automatic logic [7:0] ctlIndex(input int k);
    case (k)
      0:       ctlIndex = 8'h20;
      1:       ctlIndex = 8'h21;
      2:       ctlIndex = 8'h10;
      default: ctlIndex = 8'h11;
    endcase
  endfunction

endpackage

// File: rtl/clut_ctrl.sv
module clut_ctrl
  import clut_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              hostWe,
  input  logic [1:0]        hostSel,
  input  logic [ADDR_W-1:0] hostData,
  output logic [ADDR_W-1:0] addrQ,
  output clutStrobe_t       strobe
);

  chanSel_t chanQ;

  always_comb begin
    strobe = '0;
    if (hostWe) begin
      case (hostSel)
        PORT_LUT: begin
          case (chanQ)
            CH_RED:  strobe.ldRed  = 1'b1;
            CH_GRN:  strobe.ldGrn  = 1'b1;
            default: strobe.commit = 1'b1;
          endcase
        end
        PORT_CTL: strobe.ctlWr = 1'b1;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      addrQ <= '0;
      chanQ <= CH_RED;
    end else if (hostWe && hostSel == PORT_INDEX) begin
      addrQ <= hostData;
      chanQ <= CH_RED;
    end else if (strobe.ldRed) begin
      chanQ <= CH_GRN;
    end else if (strobe.ldGrn) begin
      chanQ <= CH_BLU;
    end else if (strobe.commit) begin
      chanQ <= CH_RED;
      addrQ <= addrQ + 1'b1;
    end
  end

  // R5: sequencer never leaves the three legal channel states
  p_chan_legal_r5: assert property (@(posedge clk) disable iff (rst)
    chanQ != 2'd3);

  // R5 R6: a commit moves the index on by exactly one, modulo the width
  p_commit_advance_r5: assert property (@(posedge clk) disable iff (rst)
    strobe.commit |=> (addrQ == ADDR_W'($past(addrQ) + 1)) && chanQ == CH_RED);

  // R7: an index write restarts the sequence at red
  p_index_restart_r7: assert property (@(posedge clk) disable iff (rst)
    (hostWe && hostSel == PORT_INDEX) |=> chanQ == CH_RED && addrQ == $past(hostData));

  // R9: control writes leave index and sequence alone
  p_ctl_no_move_r9: assert property (@(posedge clk) disable iff (rst)
    strobe.ctlWr |=> $stable(addrQ) && $stable(chanQ));

endmodule

// File: rtl/clut_dpath.sv
module clut_dpath
  import clut_pkg::*;
#(
  parameter int ENTRIES = 256,
  parameter int IDX_W   = $clog2(ENTRIES),
  parameter int ADDR_W  = 8
) (
  input  logic                clk,
  input  logic                rst,
  input  clutStrobe_t         strobe,
  input  logic [ADDR_W-1:0]   addrQ,
  input  logic [CHAN_W-1:0]   hostData,
  input  logic [7:0]          ctlRdAddr,
  output logic [CHAN_W-1:0]   ctlRdData,
  input  logic [IDX_W-1:0]    pixIdx,
  output logic [3*CHAN_W-1:0] pixRgb
);

  localparam int RGB_W = 3 * CHAN_W;

  logic [CHAN_W-1:0] stageRed, stageGrn;
  logic [RGB_W-1:0]  palette [ENTRIES];
  logic [CHAN_W-1:0] ctlReg  [NUM_CTL];
  logic [IDX_W-1:0]  wrIdx;

  assign wrIdx = addrQ[IDX_W-1:0];

  always_ff @(posedge clk) begin
    if (strobe.ldRed) stageRed <= hostData;
    if (strobe.ldGrn) stageGrn <= hostData;
  end

  always_ff @(posedge clk) begin
    if (strobe.commit) palette[wrIdx] <= {stageRed, stageGrn, hostData};
    pixRgb <= palette[pixIdx];
  end

  for (genvar k = 0; k < NUM_CTL; k++) begin : g_ctl
    always_ff @(posedge clk) begin
      if (rst)
        ctlReg[k] <= '0;
      else if (strobe.ctlWr && addrQ == ADDR_W'(ctlIndex(k)))
        ctlReg[k] <= hostData;
    end

    // R9: a register holds unless its own control write arrives
    p_ctl_hold_r9: assert property (@(posedge clk) disable iff (rst)
      !strobe.ctlWr |=> $stable(ctlReg[k]));
  end

  always_comb begin
    ctlRdData = '0;
    for (int k = 0; k < NUM_CTL; k++)
      if (ctlRdAddr == ctlIndex(k)) ctlRdData = ctlReg[k];
  end

  // R9: at most one action per host write
  p_one_strobe_r9: assert property (@(posedge clk) disable iff (rst)
    $onehot0({strobe.ldRed, strobe.ldGrn, strobe.commit, strobe.ctlWr}));

endmodule

// File: rtl/clut_port.sv
module clut_port
  import clut_pkg::*;
#(
  parameter int ENTRIES = 256,
  parameter int IDX_W   = $clog2(ENTRIES)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              hostWe,
  input  logic [1:0]        hostSel,
  input  logic [7:0]        hostData,
  input  logic [7:0]        ctlRdAddr,
  output logic [7:0]        ctlRdData,
  input  logic [IDX_W-1:0]  pixIdx,
  output logic [23:0]       pixRgb
);

  localparam int ADDR_W = 8;

  logic [ADDR_W-1:0] addrQ;
  clutStrobe_t       strobe;

  clut_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
    .clk(clk), .rst(rst), .hostWe(hostWe), .hostSel(hostSel),
    .hostData(hostData), .addrQ(addrQ), .strobe(strobe)
  );

  clut_dpath #(.ENTRIES(ENTRIES), .IDX_W(IDX_W), .ADDR_W(ADDR_W)) u_dpath (
    .clk(clk), .rst(rst), .strobe(strobe), .addrQ(addrQ),
    .hostData(hostData), .ctlRdAddr(ctlRdAddr), .ctlRdData(ctlRdData),
    .pixIdx(pixIdx), .pixRgb(pixRgb)
  );

endmodule

// File: tb/clut_port_bench.sv
`timescale 1ns/1ps
module clut_port_bench;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        hostWe = 1'b0;
  logic [1:0]  hostSel = 2'd0;
  logic [7:0]  hostData = 8'd0;
  logic [7:0]  ctlRdAddr = 8'd0;
  logic [7:0]  ctlRdData;
  logic [7:0]  pixIdx = 8'd0;
  logic [23:0] pixRgb;

  int applied = 0;
  int miscompares = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  clut_port u_clut_port (
    .clk(clk), .rst(rst), .hostWe(hostWe), .hostSel(hostSel),
    .hostData(hostData), .ctlRdAddr(ctlRdAddr), .ctlRdData(ctlRdData),
    .pixIdx(pixIdx), .pixRgb(pixRgb)
  );

  task automatic chk(input string req, input logic [23:0] act, input logic [23:0] exp);
    applied++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s: actual %06h expected %06h", req, act, exp);
    end
  endtask

  task automatic hw(input logic [1:0] sel, input logic [7:0] d);
    @(negedge clk);
    hostWe = 1'b1; hostSel = sel; hostData = d;
    @(negedge clk);
    hostWe = 1'b0;
  endtask

  task automatic triplet(input logic [7:0] r, input logic [7:0] g, input logic [7:0] b);
    hw(2'd1, r); hw(2'd1, g); hw(2'd1, b);
  endtask

  task automatic readPix(input logic [7:0] idx, output logic [23:0] v);
    @(negedge clk); pixIdx = idx;
    @(negedge clk); v = pixRgb;
  endtask

  task automatic readCtl(input logic [7:0] idx, output logic [7:0] v);
    @(negedge clk); ctlRdAddr = idx; #1; v = ctlRdData;
  endtask

  task automatic t_reset;
    logic [7:0] c; logic [23:0] v;
    readCtl(8'h20, c); chk("R1 ctl20", {16'h0, c}, 24'h0);
    readCtl(8'h21, c); chk("R1 ctl21", {16'h0, c}, 24'h0);
    readCtl(8'h10, c); chk("R1 ctl10", {16'h0, c}, 24'h0);
    readCtl(8'h11, c); chk("R1 ctl11", {16'h0, c}, 24'h0);
    triplet(8'hA1, 8'hB2, 8'hC3);
    readPix(8'd0, v); chk("R1 first triplet at entry 0", v, 24'hA1B2C3);
  endtask

  task automatic t_basic;
    logic [23:0] v;
    hw(2'd0, 8'd5); triplet(8'h11, 8'h22, 8'h33);
    readPix(8'd5, v); chk("R2 R3 entry 5", v, 24'h112233);
    hw(2'd0, 8'd128); triplet(8'hFF, 8'h00, 8'h80);
    readPix(8'd128, v); chk("R3 entry 128", v, 24'hFF0080);
  endtask

  task automatic t_blue_only;
    logic [23:0] v;
    hw(2'd0, 8'd9); triplet(8'h01, 8'h02, 8'h03);
    hw(2'd0, 8'd9); hw(2'd1, 8'h44); hw(2'd1, 8'h55);
    readPix(8'd9, v); chk("R4 no commit before blue", v, 24'h010203);
    hw(2'd1, 8'h66);
    readPix(8'd9, v); chk("R4 commit on blue", v, 24'h445566);
  endtask

  task automatic t_autoinc;
    logic [23:0] v;
    hw(2'd0, 8'd20);
    triplet(8'h10, 8'h11, 8'h12);
    triplet(8'h20, 8'h21, 8'h22);
    readPix(8'd20, v); chk("R5 entry 20", v, 24'h101112);
    readPix(8'd21, v); chk("R5 entry 21", v, 24'h202122);
  endtask

  task automatic t_wrap;
    logic [23:0] v;
    hw(2'd0, 8'd255);
    triplet(8'hE0, 8'hE1, 8'hE2);
    triplet(8'hD0, 8'hD1, 8'hD2);
    readPix(8'd255, v); chk("R6 entry 255", v, 24'hE0E1E2);
    readPix(8'd0, v);   chk("R6 wrap to entry 0", v, 24'hD0D1D2);
  endtask

  task automatic t_discard;
    logic [23:0] v;
    hw(2'd0, 8'd30); hw(2'd1, 8'h77); hw(2'd1, 8'h88);
    hw(2'd0, 8'd30); triplet(8'h9A, 8'hBC, 8'hDE);
    readPix(8'd30, v); chk("R7 partial discarded", v, 24'h9ABCDE);
  endtask

  task automatic t_ctl;
    logic [7:0] c;
    hw(2'd0, 8'h20); hw(2'd2, 8'hA5);
    hw(2'd0, 8'h21); hw(2'd2, 8'h5A);
    hw(2'd0, 8'h10); hw(2'd2, 8'hC3);
    hw(2'd0, 8'h11); hw(2'd2, 8'h3C);
    readCtl(8'h20, c); chk("R8 ctl20", {16'h0, c}, 24'hA5);
    readCtl(8'h21, c); chk("R8 ctl21", {16'h0, c}, 24'h5A);
    readCtl(8'h10, c); chk("R8 ctl10", {16'h0, c}, 24'hC3);
    readCtl(8'h11, c); chk("R8 ctl11", {16'h0, c}, 24'h3C);
  endtask

  task automatic t_ignore;
    logic [7:0] c; logic [23:0] v;
    hw(2'd0, 8'h40); hw(2'd2, 8'hFF); hw(2'd3, 8'hEE);
    readCtl(8'h20, c); chk("R9 ctl20 untouched", {16'h0, c}, 24'hA5);
    readCtl(8'h21, c); chk("R9 ctl21 untouched", {16'h0, c}, 24'h5A);
    readCtl(8'h10, c); chk("R9 ctl10 untouched", {16'h0, c}, 24'hC3);
    readCtl(8'h11, c); chk("R9 ctl11 untouched", {16'h0, c}, 24'h3C);
    readCtl(8'h40, c); chk("R9 unknown index reads 0", {16'h0, c}, 24'h0);
    hw(2'd1, 8'h10); hw(2'd1, 8'h20); hw(2'd2, 8'h99); hw(2'd1, 8'h30);
    readPix(8'h40, v); chk("R9 sequence kept across ctl write", v, 24'h102030);
    hw(2'd0, 8'h21); hw(2'd2, 8'h77); triplet(8'h01, 8'h02, 8'h03);
    readPix(8'h21, v); chk("R9 index kept across ctl write", v, 24'h010203);
    readCtl(8'h21, c); chk("R8 ctl21 rewritten", {16'h0, c}, 24'h77);
  endtask

  task automatic t_latency;
    logic [23:0] v;
    @(negedge clk); pixIdx = 8'd5;
    @(negedge clk); pixIdx = 8'd20; v = pixRgb;
    chk("R10 old value before edge", v, 24'h112233);
    @(negedge clk); v = pixRgb;
    chk("R10 new value one cycle later", v, 24'h101112);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    t_reset;
    t_basic;
    t_blue_only;
    t_autoinc;
    t_wrap;
    t_discard;
    t_ctl;
    t_ignore;
    t_latency;
    if (!finished) begin
      finished = 1'b1;
      $display("  == %0d vectors applied, %0d miscompares ==", applied, miscompares);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      applied++; miscompares++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  == %0d vectors applied, %0d miscompares ==", applied, miscompares);
      $finish;
    end
  end

endmodule